// File: doc/BRIEF.md
# Timer Compare Status Register

This block is the control and status register of one 8-bit timer channel that has two compare registers. It watches the running count against both compare values and takes an overflow pulse from the counter. Each of these events raises its own sticky flag. The register also holds four output-select bits for the pin waveform logic further downstream. Depending on the channel, it holds either a writable trigger-enable bit or a bit that always reads as 1.

Software can drop a flag only through a two-step handshake. First a read must return the flag as 1. A later write of 0 to that bit then clears it. A write of 1 to a flag bit does nothing. A transfer controller that was started by a compare interrupt can also clear that compare flag, provided its disable-select input is low. The interrupt request for each flag is the flag gated by an enable input.

Top module: `tmr_csr`

## Requirements
- R1: After reset, `csr_q` reads 8'h00 when parameter CHANNEL is 0 and 8'h10 when CHANNEL is 1.
- R2: In the first cycle in which `cnt_val` equals `cmp_b`, flag bit 7 is set, and it reads 1 from the following cycle.
- R3: In the first cycle in which `cnt_val` equals `cmp_a`, flag bit 6 is set, and it reads 1 from the following cycle.
- R4: A one-cycle `ovf_pulse` sets flag bit 5, which reads 1 from the following cycle.
- R5: A write of 0 to a flag bit (7, 6 or 5) is ignored unless a read has returned that flag as 1 since the flag was last cleared. A write of 1 to a flag bit never changes it.
- R6: After a read that returns a flag as 1, a later write with that bit at 0 clears the flag from the next cycle on. The handshake is then spent and must be repeated.
- R7: If a setting event occurs in the same cycle as any clear, the flag reads 1 afterwards.
- R8: A pulse on `xfer_ack_a` (or `xfer_ack_b`) with `dsel_a` (or `dsel_b`) at 0 clears flag bit 6 (or 7) without a prior read. With the disable-select input at 1, the pulse has no effect.
- R9: Bits 3:0 take the written value on every write. On channel 0, bit 4 is also read/write.
- R10: On channel 1, bit 4 always reads 1, and writes to it are ignored.
- R11: `irq_cmb`, `irq_cma` and `irq_ovf` equal flag bits 7, 6 and 5 ANDed with `irq_en_b`, `irq_en_a` and `irq_en_ovf` respectively.
- R12: A compare equality that lasts several cycles sets its flag only once. A flag cleared while the equality still holds stays 0 until the equality ends and then begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Register read strobe (one cycle) |
| bus_wr | input | 1 | Register write strobe (one cycle) |
| bus_wdata | input | 8 | Write data |
| csr_q | output | 8 | Register contents / read data: [7] match B, [6] match A, [5] overflow, [4] trigger enable, [3:0] output select |
| cnt_val | input | 8 | Current counter value |
| cmp_a | input | 8 | Compare value A |
| cmp_b | input | 8 | Compare value B |
| ovf_pulse | input | 1 | Counter overflow event, one cycle |
| xfer_ack_a | input | 1 | Transfer controller started by compare A interrupt |
| xfer_ack_b | input | 1 | Transfer controller started by compare B interrupt |
| dsel_a | input | 1 | Disable-select for ack A; 1 keeps the flag |
| dsel_b | input | 1 | Disable-select for ack B; 1 keeps the flag |
| irq_en_a | input | 1 | Interrupt enable for compare A |
| irq_en_b | input | 1 | Interrupt enable for compare B |
| irq_en_ovf | input | 1 | Interrupt enable for overflow |
| irq_cma | output | 1 | Compare A interrupt request |
| irq_cmb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The random phase keeps the counter and both compare values within 0 to 3. This makes equalities frequent, so they start, persist and end often. It also mixes reads, writes, overflow pulses and acknowledges with random data, so clears collide with sets and with one another, and writes of 0 arrive both with and without an earlier read. Directed sequences then separate the cases that a plain "write 0 clears" design would get wrong: a write without a read, a write of 1 after a read, and a second write after a spent handshake. Further sequences cover an equality held across a clear, acknowledges with the disable-select input high and low, and a set colliding with a clear. Both channel variants receive the same stimulus, which shows the difference at bit 4.

// File: rtl/tmr_csr_pkg.sv
// Package: bit positions and reset values shared by the compare status register.
package tmr_csr_pkg;
    localparam int CSR_W   = 8;
    localparam int FLG_N   = 3;   // overflow, match A, match B
    localparam int FLG_LO  = 5;   // lowest flag bit position
    localparam int OS_W    = 4;   // output-select width
    localparam int CTRL_W  = OS_W + 1;
    localparam int BIT_TRG = 4;

    typedef enum int {
        FLG_OVF = 0,
        FLG_CMA = 1,
        FLG_CMB = 2
    } flag_idx_e;

    // Reset image of the control field for a given channel variant.
    function automatic logic [CTRL_W-1:0] ctrl_reset(input int channel);
        return (channel == 1) ? CTRL_W'(1 << BIT_TRG) : '0;
    endfunction
endpackage

// File: rtl/tmr_csr_match.sv
// Compare edge detector: pulses for one cycle when the counter first equals
// the compare value. Assumes both inputs come from registers in the same clock domain.
module tmr_csr_match #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] cmp_val,
    output logic         hit_pulse
);
    logic eq_now;
    logic eq_prev;

    // Equality of the current counter and compare value.
    assign eq_now = (cnt_val == cmp_val);

    // Remember last cycle's equality so that only its start is reported.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_prev <= 1'b0;
        else        eq_prev <= eq_now;
    end

    // Event on the first cycle of equality only.
    assign hit_pulse = eq_now & ~eq_prev;
endmodule

// File: rtl/tmr_csr_flag.sv
// One sticky status flag with a read-arm latch. A write of 0 clears the flag only
// once a read has seen it at 1. A hardware clear needs no arming. A set beats any
// clear in the same cycle. Assumes read and write strobes are single-cycle.
module tmr_csr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic bus_rd,
    input  logic wr_zero,
    input  logic hw_clr,
    output logic flag_q
);
    logic arm_q;
    logic clr;

    // A clear request from either the armed handshake or the hardware path.
    assign clr = (wr_zero & arm_q) | hw_clr;

    // Flag state: a set has priority, otherwise a clear drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    // Arm latch: taken by a read that sees 1, spent by any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                arm_q <= 1'b0;
        else if (clr)              arm_q <= 1'b0;
        else if (bus_rd && flag_q) arm_q <= 1'b1;
    end
endmodule

// File: rtl/tmr_csr_ctrl.sv
// Control field: four output-select bits plus the bit-4 variant for the channel.
// Channel 0 has a read/write trigger enable. Channel 1 keeps bit 4 at 1.
module tmr_csr_ctrl
    import tmr_csr_pkg::*;
#(
    parameter int CHANNEL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q
);
    localparam logic [CTRL_W-1:0] RST_VAL = ctrl_reset(CHANNEL);

    // Output-select bits load on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q[OS_W-1:0] <= RST_VAL[OS_W-1:0];
        else if (bus_wr) ctrl_q[OS_W-1:0] <= wdata[OS_W-1:0];
    end

    generate
        if (CHANNEL == 1) begin : g_trg_fixed
            // Bit 4 resets to 1; a write can only OR into it, so it stays 1.
            always_ff @(posedge clk) begin
                if (!rst_n)      ctrl_q[BIT_TRG] <= 1'b1;
                else if (bus_wr) ctrl_q[BIT_TRG] <= ctrl_q[BIT_TRG] | wdata[BIT_TRG];
            end
        end else begin : g_trg_rw
            // Bit 4 is an ordinary read/write trigger-enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)      ctrl_q[BIT_TRG] <= RST_VAL[BIT_TRG];
                else if (bus_wr) ctrl_q[BIT_TRG] <= wdata[BIT_TRG];
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_csr.sv
// Timer compare status register top. It detects match and overflow events, keeps
// the three handshake-cleared flags and the control field, and gates the interrupt
// requests. Assumes single-cycle strobes and no read and write in the same cycle.
module tmr_csr
    import tmr_csr_pkg::*;
#(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [CSR_W-1:0] bus_wdata,
    output logic [CSR_W-1:0] csr_q,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             ovf_pulse,
    input  logic             xfer_ack_a,
    input  logic             xfer_ack_b,
    input  logic             dsel_a,
    input  logic             dsel_b,
    input  logic             irq_en_a,
    input  logic             irq_en_b,
    input  logic             irq_en_ovf,
    output logic             irq_cma,
    output logic             irq_cmb,
    output logic             irq_ovf
);
    logic              hit_a;
    logic              hit_b;
    logic [FLG_N-1:0]  evt;
    logic [FLG_N-1:0]  hw_clr;
    logic [FLG_N-1:0]  flags;
    logic [CTRL_W-1:0] ctrl;

    tmr_csr_match #(.W(CNT_W)) u_match_a (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_a), .hit_pulse(hit_a)
    );
    tmr_csr_match #(.W(CNT_W)) u_match_b (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cmp_val(cmp_b), .hit_pulse(hit_b)
    );

    // Gather set events and hardware clears in flag-index order.
    always_comb begin
        evt              = '0;
        hw_clr           = '0;
        evt[FLG_OVF]     = ovf_pulse;
        evt[FLG_CMA]     = hit_a;
        evt[FLG_CMB]     = hit_b;
        hw_clr[FLG_CMA]  = xfer_ack_a & ~dsel_a;
        hw_clr[FLG_CMB]  = xfer_ack_b & ~dsel_b;
    end

    generate
        for (genvar i = 0; i < FLG_N; i++) begin : g_flag
            tmr_csr_flag u_flag (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_evt(evt[i]),
                .bus_rd (bus_rd),
                .wr_zero(bus_wr & ~bus_wdata[FLG_LO+i]),
                .hw_clr (hw_clr[i]),
                .flag_q (flags[i])
            );
        end
    endgenerate

    tmr_csr_ctrl #(.CHANNEL(CHANNEL)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .wdata(bus_wdata[CTRL_W-1:0]), .ctrl_q(ctrl)
    );

    // Register image and gated interrupt requests.
    assign csr_q   = {flags, ctrl};
    assign irq_cma = flags[FLG_CMA] & irq_en_a;
    assign irq_cmb = flags[FLG_CMB] & irq_en_b;
    assign irq_ovf = flags[FLG_OVF] & irq_en_ovf;
endmodule

// File: rtl/tmr_csr_chk.sv
// Checker for tmr_csr, bound to every instance. It observes ports only.
module tmr_csr_chk #(
    parameter int CHANNEL = 0,
    parameter int CNT_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       csr_q,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ovf_pulse,
    input logic             xfer_ack_a,
    input logic             xfer_ack_b,
    input logic             dsel_a,
    input logic             dsel_b,
    input logic             irq_cma,
    input logic             irq_cmb,
    input logic             irq_ovf
);
    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> csr_q[5]);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_q[5]) |-> $past(bus_wr));

    // R8
    cma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_q[6]) |-> ($past(bus_wr) || $past(xfer_ack_a && !dsel_a)));

    // R8
    cmb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(csr_q[7]) |-> ($past(bus_wr) || $past(xfer_ack_b && !dsel_b)));

    // R9
    os_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (csr_q[3:0] == $past(bus_wdata[3:0])));

    // R10
    trg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CHANNEL == 1) |-> csr_q[4]);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cma |-> csr_q[6]) and (irq_cmb |-> csr_q[7]) and (irq_ovf |-> csr_q[5]));
endmodule

bind tmr_csr tmr_csr_chk #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .csr_q(csr_q), .cnt_val(cnt_val), .ovf_pulse(ovf_pulse),
    .xfer_ack_a(xfer_ack_a), .xfer_ack_b(xfer_ack_b),
    .dsel_a(dsel_a), .dsel_b(dsel_b),
    .irq_cma(irq_cma), .irq_cmb(irq_cmb), .irq_ovf(irq_ovf)
);

// File: tb/tmr_csr_tb.sv
module tmr_csr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] cnt_val = 8'd0, cmp_a = 8'd1, cmp_b = 8'd2;
    logic       ovf_pulse = 1'b0, xfer_ack_a = 1'b0, xfer_ack_b = 1'b0;
    logic       dsel_a = 1'b0, dsel_b = 1'b0;
    logic       irq_en_a = 1'b0, irq_en_b = 1'b0, irq_en_ovf = 1'b0;
    logic [7:0] csr0, csr1;
    logic [2:0] irq0, irq1;

    int n_chk = 0;
    int n_bad = 0;

    // Model state per channel
    logic [7:0] m_csr [2];
    logic [2:0] m_arm [2];
    logic       m_pa  [2];
    logic       m_pb  [2];

    always #5 clk = ~clk;

    tmr_csr #(.CHANNEL(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .csr_q(csr0), .cnt_val(cnt_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .ovf_pulse(ovf_pulse),
        .xfer_ack_a(xfer_ack_a), .xfer_ack_b(xfer_ack_b), .dsel_a(dsel_a), .dsel_b(dsel_b),
        .irq_en_a(irq_en_a), .irq_en_b(irq_en_b), .irq_en_ovf(irq_en_ovf),
        .irq_cma(irq0[1]), .irq_cmb(irq0[2]), .irq_ovf(irq0[0])
    );
    tmr_csr #(.CHANNEL(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .csr_q(csr1), .cnt_val(cnt_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .ovf_pulse(ovf_pulse),
        .xfer_ack_a(xfer_ack_a), .xfer_ack_b(xfer_ack_b), .dsel_a(dsel_a), .dsel_b(dsel_b),
        .irq_en_a(irq_en_a), .irq_en_b(irq_en_b), .irq_en_ovf(irq_en_ovf),
        .irq_cma(irq1[1]), .irq_cmb(irq1[2]), .irq_ovf(irq1[0])
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] reset_val(input int ch);
        return (ch == 1) ? 8'h10 : 8'h00;
    endfunction

    function automatic logic [2:0] irq_exp(input logic [7:0] c);
        return {c[7] & irq_en_b, c[6] & irq_en_a, c[5] & irq_en_ovf};
    endfunction

    // Next-state model built from R2..R10 and R12, using the inputs of this cycle.
    task automatic model_step(input int ch);
        logic [2:0] set, clr, flg, nflg, narm;
        logic       eqa, eqb;
        eqa    = (cnt_val == cmp_a);
        eqb    = (cnt_val == cmp_b);
        set    = {eqb & ~m_pb[ch], eqa & ~m_pa[ch], ovf_pulse};
        flg    = m_csr[ch][7:5];
        for (int i = 0; i < 3; i++) begin
            clr[i] = bus_wr & ~bus_wdata[5+i] & m_arm[ch][i];
        end
        clr[1] = clr[1] | (xfer_ack_a & ~dsel_a);
        clr[2] = clr[2] | (xfer_ack_b & ~dsel_b);
        for (int i = 0; i < 3; i++) begin
            nflg[i] = set[i] | (flg[i] & ~clr[i]);
            narm[i] = clr[i] ? 1'b0 : ((bus_rd & flg[i]) ? 1'b1 : m_arm[ch][i]);
        end
        m_csr[ch][7:5] = nflg;
        m_arm[ch]      = narm;
        if (bus_wr) begin
            m_csr[ch][3:0] = bus_wdata[3:0];
            if (ch == 0) m_csr[ch][4] = bus_wdata[4];
        end
        m_pa[ch] = eqa;
        m_pb[ch] = eqb;
    endtask

    // One clock with the current inputs, then compare both channels.
    task automatic step(input string tag);
        @(posedge clk);
        model_step(0);
        model_step(1);
        @(negedge clk);
        chk({tag, " ch0 csr"}, csr0, m_csr[0]);
        chk({tag, " ch1 csr"}, csr1, m_csr[1]);
        chk({tag, " ch0 irq R11"}, {5'd0, irq0}, {5'd0, irq_exp(m_csr[0])});
        chk({tag, " ch1 irq R11"}, {5'd0, irq1}, {5'd0, irq_exp(m_csr[1])});
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; ovf_pulse = 0; xfer_ack_a = 0; xfer_ack_b = 0;
    endtask

    task automatic rd_op(input string tag);
        idle(); bus_rd = 1; step(tag); idle();
    endtask

    task automatic wr_op(input string tag, input logic [7:0] d);
        idle(); bus_wr = 1; bus_wdata = d; step(tag); idle();
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        for (int ch = 0; ch < 2; ch++) begin
            m_csr[ch] = reset_val(ch); m_arm[ch] = 3'b000; m_pa[ch] = 0; m_pb[ch] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset image
        chk("R1 ch0 reset", csr0, 8'h00);
        chk("R1 ch1 reset", csr1, 8'h10);

        // R4 overflow set; R5 write 0 without read ignored
        irq_en_ovf = 1;
        ovf_pulse = 1; step("R4 overflow set"); idle();
        chk("R4 ovf bit", {7'd0, csr0[5]}, 8'd1);
        wr_op("R5 unarmed write 0", 8'h00);
        chk("R5 ovf kept", {7'd0, csr0[5]}, 8'd1);
        // R6 read then write 1 keeps, then write 0 clears
        rd_op("R6 read");
        wr_op("R5 write 1 no effect", 8'hE0);
        chk("R5 ovf kept after write 1", {7'd0, csr0[5]}, 8'd1);
        wr_op("R6 armed write 0", 8'h00);
        chk("R6 ovf cleared", {7'd0, csr0[5]}, 8'd0);
        // R6 spent handshake
        ovf_pulse = 1; step("R6 re-set"); idle();
        wr_op("R6 spent write", 8'h00);
        chk("R6 not cleared without new read", {7'd0, csr0[5]}, 8'd1);

        // R3 / R12 held equality
        cnt_val = 8'd5; cmp_a = 8'd5; step("R3 match A");
        chk("R3 flag A", {7'd0, csr0[6]}, 8'd1);
        bus_rd = 1; step("R12 hold read"); idle();
        bus_wr = 1; bus_wdata = 8'h00; step("R12 clear while equal"); idle();
        step("R12 still equal");
        chk("R12 no re-set", {7'd0, csr0[6]}, 8'd0);
        cnt_val = 8'd6; step("R12 leave");
        cnt_val = 8'd5; step("R12 re-enter");
        chk("R12 re-set", {7'd0, csr0[6]}, 8'd1);

        // R8 acknowledge paths
        dsel_a = 1; xfer_ack_a = 1; step("R8 ack kept"); idle();
        chk("R8 dsel high keeps", {7'd0, csr0[6]}, 8'd1);
        dsel_a = 0; xfer_ack_a = 1; step("R8 ack clears"); idle();
        chk("R8 dsel low clears", {7'd0, csr0[6]}, 8'd0);

        // R2 and R7 set beats clear
        cmp_b = 8'd9; cnt_val = 8'd9; step("R2 match B");
        chk("R2 flag B", {7'd0, csr0[7]}, 8'd1);
        cnt_val = 8'd0; step("R7 prep");
        cnt_val = 8'd9; xfer_ack_b = 1; dsel_b = 0; step("R7 set with ack"); idle();
        chk("R7 set wins", {7'd0, csr0[7]}, 8'd1);

        // R9 / R10 control field
        wr_op("R9 write ctrl", 8'h1A);
        chk("R9 ch0 ctrl", {3'd0, csr0[4:0]}, 8'h1A);
        wr_op("R10 write bit4 low", 8'h05);
        chk("R10 ch1 bit4", {3'd0, csr1[4:0]}, 8'h15);
        chk("R9 ch0 bit4 low", {3'd0, csr0[4:0]}, 8'h05);

        // Random phase
        for (int k = 0; k < 600; k++) begin
            idle();
            cnt_val    = 8'($urandom_range(0, 3));
            cmp_a      = 8'($urandom_range(0, 3));
            cmp_b      = 8'($urandom_range(0, 3));
            ovf_pulse  = ($urandom_range(0, 7) == 0);
            xfer_ack_a = ($urandom_range(0, 7) == 0);
            xfer_ack_b = ($urandom_range(0, 7) == 0);
            dsel_a     = 1'($urandom_range(0, 1));
            dsel_b     = 1'($urandom_range(0, 1));
            irq_en_a   = 1'($urandom_range(0, 1));
            irq_en_b   = 1'($urandom_range(0, 1));
            irq_en_ovf = 1'($urandom_range(0, 1));
            bus_wdata  = 8'($urandom);
            case ($urandom_range(0, 3))
                0: bus_rd = 1;
                1: bus_wr = 1;
                default: ;
            endcase
            step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
        end
        idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule